// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is a small first-level cache built from a direct-mapped main array and a fully associative victim buffer. Both structures are searched in the same cycle for every request. Each request carries a block address. The low bits of that address pick the one main-array slot the block may occupy, and the high bits are stored there as the tag. The victim buffer keeps the whole block address of each line it holds, so any of its slots may hold any block.

A line that leaves the main array while still valid is not dropped. It is moved into the victim buffer. A later request for that block finds it there: the line moves back into its main-array slot, and whatever occupied that slot takes its place in the buffer. This recovers blocks lost to conflicts between addresses that share a main-array index. On a full miss the fill data that arrives with the request is installed in the main array. A request may instead ask to invalidate a block, which removes it from whichever structure holds it.

Every lookup produces exactly one of three registered results, one clock after the request: a main hit, a victim hit or a miss. Read data is registered with the result.

Top module: `victim_dm_cache`

## Requirements
- R1: After a synchronous active-low reset, all three result outputs are low and every structure is empty, so the first lookup of any address reports a miss.
- R2: The main-array slot is the block address modulo MAIN_ENTRIES, given by the low address bits. Two addresses with the same low bits and different high bits conflict, so the second one misses in the main array.
- R3: A lookup whose address is held valid in the main array reports hit_main and returns that line's data, and it changes no state.
- R4: A miss that replaces a valid main-array line writes the old line, with its full address and data, into the victim buffer. A later lookup of that address reports hit_victim with the old data.
- R5: On a victim hit, the hit line returns to its main-array slot and the line displaced from that slot takes the freed victim slot. Repeating the same address then gives hit_main, and the displaced address gives hit_victim.
- R6: Outputs are registered. A lookup presented before clock edge N raises exactly one of hit_main, hit_victim and miss in the cycle after edge N. A cycle with no lookup raises none of them.
- R7: On a miss, fill_data is written into the main array and is also returned on rd_data.
- R8: With more than one victim slot, new victims go to a rotating slot pointer. When all slots are full, the entry that was inserted longest ago is overwritten first.
- R9: An invalidate request (req_valid with req_inv=1) raises no result output. It clears the address from the main array or the victim buffer, so the next lookup of that address misses. A miss into an empty main slot leaves the victim buffer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_inv | input | 1 | 1: invalidate the address, 0: lookup |
| req_addr | input | ADDR_W | Block address |
| fill_data | input | DATA_W | Line data installed on a miss |
| hit_main | output | 1 | Previous lookup hit in the main array |
| hit_victim | output | 1 | Previous lookup hit in the victim buffer |
| miss | output | 1 | Previous lookup missed in both structures |
| rd_data | output | DATA_W | Line data of the previous lookup |

## Verification
The bench first replays a conflict sequence through the default one-slot buffer: four cold fills, then a block mapped onto an occupied slot, a return to the evicted block, and repeated ping-pong between two blocks of one index. This separates plain hits, swaps and true misses. A high address that shares an index with small ones checks that tag and index are split correctly. Invalidations of lines held in the main array and in the buffer show that a cleared line misses and that a fill into an empty slot does not evict anything. Finally, a two-slot buffer is filled past capacity with four blocks of one index, which shows which victim is overwritten first.

// File: rtl/victim_dm_cache_pkg.sv
// Package: shared result encoding for the victim-buffered cache.
// Assumes: one result per lookup; RES_NONE for idle or invalidate cycles.
package victim_dm_cache_pkg;
    typedef enum logic [1:0] {
        RES_NONE = 2'd0,
        RES_MAIN = 2'd1,
        RES_VICT = 2'd2,
        RES_MISS = 2'd3
    } lookup_res_e;
endpackage

// File: rtl/vdc_main_array.sv
// Module: direct-mapped main array. Combinational read of the slot picked
// by idx, with a tag compare. One write per cycle, to the same slot.
// Assumes: ENTRIES is a power of two of at least 2; TAG_W = ADDR_W - IDX_W.
module vdc_main_array #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int ENTRIES = 4,
    parameter int IDX_W   = $clog2(ENTRIES),
    parameter int TAG_W   = ADDR_W - IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    output logic              hit,
    output logic              line_valid,
    output logic [TAG_W-1:0]  line_tag,
    output logic [DATA_W-1:0] line_data,
    input  logic              wr_en,
    input  logic              wr_valid,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data
);
    logic              vld   [ENTRIES];
    logic [TAG_W-1:0]  tags  [ENTRIES];
    logic [DATA_W-1:0] datas [ENTRIES];

    // Read the indexed slot and compare its tag.
    always_comb begin
        line_valid = vld[idx];
        line_tag   = tags[idx];
        line_data  = datas[idx];
        hit        = line_valid && (line_tag == tag);
    end

    for (genvar s = 0; s < ENTRIES; s++) begin : g_slot
        // Valid flag of each slot: cleared by reset, set or cleared by a write.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld[s] <= 1'b0;
            else if (wr_en && idx == IDX_W'(s))
                vld[s] <= wr_valid;
        end

        // Tag and data of each slot: no reset, since the valid flag guards them.
        always_ff @(posedge clk) begin
            if (wr_en && idx == IDX_W'(s)) begin
                tags[s]  <= wr_tag;
                datas[s] <= wr_data;
            end
        end
    end
endmodule

// File: rtl/vdc_victim_store.sv
// Module: fully associative victim buffer. Every slot is compared with the
// full block address. Writes go to one slot per cycle. A rotating pointer
// names the slot for the next insertion.
// Assumes: an address is held in at most one slot; ENTRIES below 8.
module vdc_victim_store #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 16,
    parameter int ENTRIES = 1,
    parameter int SLOT_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic              hit,
    output logic [SLOT_W-1:0] hit_slot,
    output logic [DATA_W-1:0] hit_data,
    output logic [SLOT_W-1:0] push_slot,
    input  logic              push,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic              vld   [ENTRIES];
    logic [ADDR_W-1:0] vaddr [ENTRIES];
    logic [DATA_W-1:0] vdata [ENTRIES];
    logic [ENTRIES-1:0] match;
    logic [SLOT_W-1:0] ptr_q;

    for (genvar k = 0; k < ENTRIES; k++) begin : g_slot
        assign match[k] = vld[k] && (vaddr[k] == lk_addr);

        // Slot valid flag: cleared by reset, updated by a write to this slot.
        always_ff @(posedge clk) begin
            if (!rst_n)
                vld[k] <= 1'b0;
            else if (wr_en && wr_slot == SLOT_W'(k))
                vld[k] <= wr_valid;
        end

        // Slot address and data, guarded by the valid flag.
        always_ff @(posedge clk) begin
            if (wr_en && wr_slot == SLOT_W'(k)) begin
                vaddr[k] <= wr_addr;
                vdata[k] <= wr_data;
            end
        end
    end

    // Encode the matching slot and OR together the data of matching slots.
    always_comb begin
        hit_slot = '0;
        hit_data = '0;
        for (int k = 0; k < ENTRIES; k++) begin
            if (match[k]) begin
                hit_slot = SLOT_W'(k);
                hit_data = hit_data | vdata[k];
            end
        end
        hit = |match;
    end

    // Insertion pointer: advances by one per insertion and wraps.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (push)
            ptr_q <= (ptr_q == SLOT_W'(ENTRIES - 1)) ? '0 : ptr_q + 1'b1;
    end

    assign push_slot = ptr_q;
endmodule

// File: rtl/victim_dm_cache.sv
// Module: top of the cache. Searches the main array and the victim buffer
// in parallel, picks one result, and updates both structures at the next
// edge: swap on a victim hit, fill and evict on a miss, clear on invalidate.
// Assumes: one request per cycle; results and data are registered.
module victim_dm_cache
    import victim_dm_cache_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int DATA_W       = 16,
    parameter int MAIN_ENTRIES = 4,
    parameter int VICT_ENTRIES = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_inv,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] fill_data,
    output logic              hit_main,
    output logic              hit_victim,
    output logic              miss,
    output logic [DATA_W-1:0] rd_data
);
    localparam int IDX_W  = $clog2(MAIN_ENTRIES);
    localparam int TAG_W  = ADDR_W - IDX_W;
    localparam int SLOT_W = (VICT_ENTRIES > 1) ? $clog2(VICT_ENTRIES) : 1;

    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic              lookup, inv;
    lookup_res_e       res;

    logic              m_hit, m_line_valid, m_wr_en, m_wr_valid;
    logic [TAG_W-1:0]  m_line_tag;
    logic [DATA_W-1:0] m_line_data, m_wr_data;

    logic              v_hit, v_push, v_wr_en, v_wr_valid;
    logic [SLOT_W-1:0] v_hit_slot, v_push_slot, v_wr_slot;
    logic [DATA_W-1:0] v_hit_data;
    logic [ADDR_W-1:0] evict_addr;

    assign idx        = req_addr[IDX_W-1:0];
    assign tag        = req_addr[ADDR_W-1:IDX_W];
    assign lookup     = req_valid && !req_inv;
    assign inv        = req_valid && req_inv;
    assign evict_addr = {m_line_tag, idx};

    vdc_main_array #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(MAIN_ENTRIES),
        .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) main_i (
        .clk(clk), .rst_n(rst_n), .idx(idx), .tag(tag),
        .hit(m_hit), .line_valid(m_line_valid), .line_tag(m_line_tag),
        .line_data(m_line_data), .wr_en(m_wr_en), .wr_valid(m_wr_valid),
        .wr_tag(tag), .wr_data(m_wr_data)
    );

    vdc_victim_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .ENTRIES(VICT_ENTRIES), .SLOT_W(SLOT_W)
    ) vict_i (
        .clk(clk), .rst_n(rst_n), .lk_addr(req_addr),
        .hit(v_hit), .hit_slot(v_hit_slot), .hit_data(v_hit_data),
        .push_slot(v_push_slot), .push(v_push), .wr_en(v_wr_en),
        .wr_slot(v_wr_slot), .wr_valid(v_wr_valid), .wr_addr(evict_addr),
        .wr_data(m_line_data)
    );

    // Pick the single lookup result; a main hit takes priority.
    always_comb begin
        if (!lookup)     res = RES_NONE;
        else if (m_hit)  res = RES_MAIN;
        else if (v_hit)  res = RES_VICT;
        else             res = RES_MISS;
    end

    // Main-array update: bring in the swapped or filled line, or clear on invalidate.
    always_comb begin
        m_wr_en    = (res == RES_VICT) || (res == RES_MISS) || (inv && m_hit);
        m_wr_valid = lookup;
        m_wr_data  = (res == RES_VICT) ? v_hit_data : fill_data;
    end

    // Victim update: take the displaced line, or clear the slot on invalidate.
    always_comb begin
        v_push     = (res == RES_MISS) && m_line_valid;
        v_wr_en    = (res == RES_VICT) || v_push || (inv && v_hit);
        v_wr_slot  = (res == RES_MISS) ? v_push_slot : v_hit_slot;
        v_wr_valid = (res == RES_VICT) ? m_line_valid : (res == RES_MISS);
    end

    // Registered result flags and read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_main   <= 1'b0;
            hit_victim <= 1'b0;
            miss       <= 1'b0;
            rd_data    <= '0;
        end else begin
            hit_main   <= (res == RES_MAIN);
            hit_victim <= (res == RES_VICT);
            miss       <= (res == RES_MISS);
            if (res == RES_MAIN)      rd_data <= m_line_data;
            else if (res == RES_VICT) rd_data <= v_hit_data;
            else if (res == RES_MISS) rd_data <= fill_data;
        end
    end
endmodule

// File: rtl/victim_dm_cache_chk.sv
// Module: assertion checker for victim_dm_cache, attached by bind.
// Assumes: it sees only the top-level ports.
module victim_dm_cache_chk #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_inv,
    input logic [ADDR_W-1:0] req_addr,
    input logic [DATA_W-1:0] fill_data,
    input logic              hit_main,
    input logic              hit_victim,
    input logic              miss,
    input logic [DATA_W-1:0] rd_data
);
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({hit_main, hit_victim, miss}) <= 1); // R6

    AST_LOOKUP_GIVES_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_inv) |=> (hit_main || hit_victim || miss)); // R6

    AST_QUIET_WITHOUT_LOOKUP: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_inv) |=> !(hit_main || hit_victim || miss)); // R9

    AST_MISS_RETURNS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> rd_data == $past(fill_data)); // R7

    AST_MAIN_HIT_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_main && req_valid && !req_inv && req_addr == $past(req_addr)) |=> hit_main); // R3

    AST_SWAP_INTO_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_victim && req_valid && !req_inv && req_addr == $past(req_addr)) |=> hit_main); // R5
endmodule

bind victim_dm_cache victim_dm_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_inv(req_inv),
    .req_addr(req_addr), .fill_data(fill_data), .hit_main(hit_main),
    .hit_victim(hit_victim), .miss(miss), .rd_data(rd_data)
);

// File: tb/victim_dm_cache_tb_top.sv
// Bench: runs a vector table through the one-slot configuration, then
// directed reset, idle and two-slot replacement-order tests.
module victim_dm_cache_tb_top;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;
    localparam int NVEC   = 30;
    // Codes: 0 none, 1 main hit, 2 victim hit, 3 miss
    localparam int VA [NVEC] = '{8, 9, 10, 11, 8, 12, 9, 10, 11, 12,
                                 8, 8, 12, 16, 8, 12, 16, 13, 12, 16,
                                 9, 13, 200, 16, 16, 16, 200, 16, 16, 200};
    localparam bit VI [NVEC] = '{0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                                 0, 0, 0, 0, 0, 0, 0, 0, 0, 0,
                                 0, 0, 0, 0, 1, 0, 0, 1, 0, 0};
    localparam int VE [NVEC] = '{3, 3, 3, 3, 1, 3, 1, 1, 1, 1,
                                 2, 1, 2, 3, 3, 3, 3, 3, 3, 2,
                                 3, 2, 3, 2, 0, 3, 2, 0, 3, 2};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_inv = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] fill_data = '0;
    logic hm1, hv1, ms1, hm2, hv2, ms2;
    logic [DATA_W-1:0] rd1, rd2;
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    victim_dm_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAIN_ENTRIES(4), .VICT_ENTRIES(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_inv(req_inv),
        .req_addr(req_addr), .fill_data(fill_data), .hit_main(hm1),
        .hit_victim(hv1), .miss(ms1), .rd_data(rd1));

    victim_dm_cache #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAIN_ENTRIES(4), .VICT_ENTRIES(2)) dut_w (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_inv(req_inv),
        .req_addr(req_addr), .fill_data(fill_data), .hit_main(hm2),
        .hit_victim(hv2), .miss(ms2), .rd_data(rd2));

    function automatic logic [DATA_W-1:0] line_of(input int a);
        return {a[7:0], ~a[7:0]};
    endfunction

    function automatic logic [2:0] code3(input int c);
        return (c == 1) ? 3'b100 : (c == 2) ? 3'b010 : (c == 3) ? 3'b001 : 3'b000;
    endfunction

    task automatic check_flags(input bit wide, input int code, input int a, input string req);
        logic [2:0] got;
        logic [DATA_W-1:0] dat;
        got = wide ? {hm2, hv2, ms2} : {hm1, hv1, ms1};
        dat = wide ? rd2 : rd1;
        n_chk++;
        if (got !== code3(code)) begin
            n_bad++;
            $display("FAIL %s addr %0d flags got %b exp %b", req, a, got, code3(code));
        end else if (code != 0 && dat !== line_of(a)) begin
            n_bad++;
            $display("FAIL %s addr %0d data got %h exp %h", req, a, dat, line_of(a));
        end
    endtask

    // Present one request at a falling edge; check the result one cycle later.
    task automatic access(input int a, input bit inv, input int code, input bit wide, input string req);
        req_valid = 1'b1;
        req_inv   = inv;
        req_addr  = ADDR_W'(a);
        fill_data = line_of(a);
        @(negedge clk);
        req_valid = 1'b0;
        req_inv   = 1'b0;
        check_flags(wide, code, a, req);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: all flags low after reset
        check_flags(1'b0, 0, 0, "R1 reset flags");
        check_flags(1'b1, 0, 0, "R1 reset flags wide");

        // Table: R2 conflicts (8/12/16/200 share slot 0), R4 eviction,
        // R5 swaps, R7 fills, R9 invalidates in main and victim.
        for (int i = 0; i < NVEC; i++) begin
            access(VA[i], VI[i], VE[i], 1'b0,
                   (VE[i] == 1) ? "R3 main hit" :
                   (VE[i] == 2) ? "R4 R5 victim hit" :
                   (VE[i] == 3) ? "R2 R7 miss" : "R9 invalidate");
        end

        // R6: an idle cycle raises no result
        @(negedge clk);
        check_flags(1'b0, 0, 0, "R6 idle");

        // R1: reset clears contents; 200 was a main line before the reset
        do_reset();
        check_flags(1'b0, 0, 0, "R1 flags after reset");
        access(200, 1'b0, 3, 1'b0, "R1 miss after reset");

        // R8: two-slot buffer, four blocks of slot 0; oldest victim 0 is overwritten
        do_reset();
        access(0,  1'b0, 3, 1'b1, "R8 fill 0");
        access(4,  1'b0, 3, 1'b1, "R8 fill 4");
        access(8,  1'b0, 3, 1'b1, "R8 fill 8");
        access(12, 1'b0, 3, 1'b1, "R8 fill 12");
        access(8,  1'b0, 2, 1'b1, "R8 victim 8 kept");
        access(4,  1'b0, 2, 1'b1, "R8 victim 4 kept");
        access(0,  1'b0, 3, 1'b1, "R8 oldest 0 dropped");

        done = 1'b1;
        summary();
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog R6 got hang exp completion");
            summary();
            $finish;
        end
    end
endmodule